// File: doc/BRIEF.md
# Periodic System Tick Timer

This block is a register-accessed down-counter that produces a regular time base for an operating system or a scheduler. Software loads a reload value and turns the counter on. The counter then steps down once per counting tick. When it passes from 1 to 0 it sets a sticky count flag and can pulse an interrupt line. On the next counting tick it reloads on its own, so one period is the reload value plus one counting ticks.

Counting ticks are either every core clock cycle or the cycles on which a reference tick-enable input is high, chosen by a control bit. Four word registers are accessed through a single-cycle port. A read returns its data combinationally in the cycle in which select is high, and a write takes effect at the clock edge that ends that cycle. Each access carries a privilege attribute. Unprivileged accesses get an error response and change nothing. A fixed calibration value can be read back.

Top module: `tick_timer_top`

## Requirements
- R1: After reset the control word, the reload value and the current value all read 0, and `irq_o` is low.
- R2: Control word (offset 0x0) layout: bit 0 enables counting, bit 1 enables the interrupt pulse, bit 2 selects the core clock (1) or the reference tick (0), and bit 16 is the count flag. A write changes only bits [2:0]. All other bits read 0, and the flag is not affected by write data.
- R3: Offset 0xC reads the constant `CAL_VALUE` (10000 by default). Any address with non-zero bits [1:0], or at or above 0x10, reads 0, and writes to it change nothing.
- R4: Writing enable from 0 to 1 loads the counter from the reload value. While enabled, the counter steps down by one on every cycle in core-clock mode, and in reference mode only on cycles where `ref_tick_i` is high.
- R5: When the counter steps from 1 to 0, the count flag is set. If interrupt enable is 1, `irq_o` is high for exactly one cycle after that edge. The next counting tick reloads the counter, so the period is reload+1 counting ticks.
- R6: Reading the current value (offset 0x8) returns 0 while counting is disabled, and a disabled counter does not change.
- R7: Reading the control word clears the count flag. An expiry in that same cycle leaves the flag set.
- R8: Any write to offset 0x8 reloads the counter from the reload value and clears the count flag. The write data is ignored.
- R9: If the reload value is 0 when the counter steps from 1 to 0, the enable bit clears and counting stops.
- R10: A control write that changes the clock-source bit while enable stays 1 reloads the counter.
- R11: An access with `bus_priv_i` low raises `bus_err_o`, returns 0 and has no side effect.
- R12: Offset 0x4 stores the low `CNT_W` bits of the write data, and the higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | Reference tick enable, used when clock-source bit is 0 |
| bus_sel_i | input | 1 | Access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_priv_i | input | 1 | 1 = privileged access |
| bus_addr_i | input | ADDR_W | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| bus_err_o | output | 1 | Error response for the access |
| irq_o | output | 1 | One-cycle expiry interrupt pulse |

## Verification
The bench builds the block with an 8-bit counter and a 5-bit address. The narrow counter makes truncation of the upper reload bits visible within a short run. The extra address bit makes the unmapped region above 0x10 reachable. Short reloads of 3 to 5 give many complete periods, irq pulses and reload-at-zero shutdowns within a few hundred cycles. In reference mode, a tick every third cycle shows counting that skips cycles.

// File: rtl/tick_pkg.sv
// Shared definitions for the tick timer: register indices and control bit positions.
// Assumes word addressing through byte address bits [3:2].
package tick_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_CUR    = 2'd2,
        REG_CAL    = 2'd3
    } tick_reg_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_TINT_BIT = 1;
    localparam int CTRL_CSRC_BIT = 2;
    localparam int CTRL_FLAG_BIT = 16;
endpackage

// File: rtl/tick_bus_dec.sv
// Bus decoder and read mux for the tick timer.
// Turns one access cycle into write/read strobes and returns read data in the same cycle.
// Assumes only word-aligned addresses below 0x10 are mapped; others read 0 and ignore writes.
module tick_bus_dec
    import tick_pkg::*;
#(
    parameter int          ADDR_W    = 5,
    parameter int          CNT_W     = 32,
    parameter logic [31:0] CAL_VALUE = 32'd10000
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              priv_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    input  logic              tint_i,
    input  logic              csrc_i,
    input  logic              flag_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  cur_i,
    output logic              wr_ctrl_o,
    output logic              wr_reload_o,
    output logic              wr_cur_o,
    output logic              rd_ctrl_o,
    output logic [31:0]       rdata_o,
    output logic              err_o
);
    logic      granted;
    logic      in_map;
    tick_reg_e idx;

    // Qualify the access and pick the addressed register.
    always_comb begin
        granted = sel_i && priv_i;
        in_map  = (addr_i[1:0] == 2'b00) && ((addr_i >> 4) == '0);
        idx     = tick_reg_e'(addr_i[3:2]);
        err_o   = sel_i && !priv_i;
    end

    // Generate the write and read strobes.
    always_comb begin
        wr_ctrl_o   = granted && wr_i  && in_map && (idx == REG_CTRL);
        wr_reload_o = granted && wr_i  && in_map && (idx == REG_RELOAD);
        wr_cur_o    = granted && wr_i  && in_map && (idx == REG_CUR);
        rd_ctrl_o   = granted && !wr_i && in_map && (idx == REG_CTRL);
    end

    // Select the read data for the addressed register.
    always_comb begin
        rdata_o = '0;
        if (granted && !wr_i && in_map) begin
            unique case (idx)
                REG_CTRL: begin
                    rdata_o[CTRL_EN_BIT]   = en_i;
                    rdata_o[CTRL_TINT_BIT] = tint_i;
                    rdata_o[CTRL_CSRC_BIT] = csrc_i;
                    rdata_o[CTRL_FLAG_BIT] = flag_i;
                end
                REG_RELOAD: rdata_o = 32'(reload_i);
                REG_CUR:    rdata_o = en_i ? 32'(cur_i) : 32'd0;
                REG_CAL:    rdata_o = CAL_VALUE;
                default:    rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/tick_ctrl.sv
// Control state of the tick timer: enable, interrupt enable, clock source, count flag,
// reload value and the registered interrupt pulse. Also decides when the counter
// loads, when a bus write holds it, and when a counting tick occurs.
// Assumes strobes from tick_bus_dec are mutually exclusive.
module tick_ctrl #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_i,
    input  logic             wr_ctrl_i,
    input  logic             wr_reload_i,
    input  logic             wr_cur_i,
    input  logic             rd_ctrl_i,
    input  logic [2:0]       ctrl_wd_i,
    input  logic [CNT_W-1:0] reload_wd_i,
    input  logic             expire_i,
    output logic             en_o,
    output logic             tint_o,
    output logic             csrc_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             load_o,
    output logic             hold_o,
    output logic             step_o,
    output logic             irq_o
);
    // Derive load, hold and counting-tick requests from the current state and bus strobes.
    always_comb begin
        load_o = wr_cur_i
               || (wr_ctrl_i && ctrl_wd_i[0] && (!en_o || (ctrl_wd_i[2] != csrc_o)));
        hold_o = wr_ctrl_i || wr_cur_i;
        step_o = en_o && (csrc_o || ref_tick_i);
    end

    // Update the control bits, the enable auto-clear and the reload register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o     <= 1'b0;
            tint_o   <= 1'b0;
            csrc_o   <= 1'b0;
            reload_o <= '0;
        end else begin
            if (wr_ctrl_i) begin
                en_o   <= ctrl_wd_i[0];
                tint_o <= ctrl_wd_i[1];
                csrc_o <= ctrl_wd_i[2];
            end else if (expire_i && (reload_o == '0)) begin
                en_o <= 1'b0;
            end
            if (wr_reload_i) begin
                reload_o <= reload_wd_i;
            end
        end
    end

    // Keep the sticky count flag and register the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            if (wr_cur_i) begin
                flag_o <= 1'b0;
            end else if (expire_i) begin
                flag_o <= 1'b1;
            end else if (rd_ctrl_i) begin
                flag_o <= 1'b0;
            end
            irq_o <= expire_i && tint_o;
        end
    end
endmodule

// File: rtl/tick_down_cnt.sv
// Down-counter of the tick timer. Loads on request, steps on counting ticks,
// reports the 1-to-0 step as expiry, and reloads on the tick after it reaches 0.
// Assumes hold_i is high whenever load_i is high.
module tick_down_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cur_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic adv;

    // Decide whether this cycle advances the count and whether it expires.
    always_comb begin
        adv      = step_i && !hold_i;
        expire_o = adv && (cur_o == ONE);
    end

    // Load, reload at zero, or decrement the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o <= '0;
        end else if (load_i) begin
            cur_o <= reload_i;
        end else if (adv) begin
            cur_o <= (cur_o == '0) ? reload_i : cur_o - ONE;
        end
    end
endmodule

// File: rtl/tick_timer_top.sv
// Top of the periodic system tick timer: bus decoder, control state and down-counter.
// Assumes single-cycle word accesses; read data is combinational in the access cycle.
module tick_timer_top #(
    parameter int          CNT_W     = 32,
    parameter int          ADDR_W    = 5,
    parameter logic [31:0] CAL_VALUE = 32'd10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic              bus_priv_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              bus_err_o,
    output logic              irq_o
);
    logic             wr_ctrl_s, wr_reload_s, wr_cur_s, rd_ctrl_s;
    logic             en_q, tint_q, csrc_q, flag_q;
    logic [CNT_W-1:0] reload_q, cur_q;
    logic             load_s, hold_s, step_s, expire_s;

    tick_bus_dec #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .CAL_VALUE(CAL_VALUE)
    ) u_dec (
        .sel_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .priv_i     (bus_priv_i),
        .addr_i     (bus_addr_i),
        .en_i       (en_q),
        .tint_i     (tint_q),
        .csrc_i     (csrc_q),
        .flag_i     (flag_q),
        .reload_i   (reload_q),
        .cur_i      (cur_q),
        .wr_ctrl_o  (wr_ctrl_s),
        .wr_reload_o(wr_reload_s),
        .wr_cur_o   (wr_cur_s),
        .rd_ctrl_o  (rd_ctrl_s),
        .rdata_o    (bus_rdata_o),
        .err_o      (bus_err_o)
    );

    tick_ctrl #(
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .wr_ctrl_i  (wr_ctrl_s),
        .wr_reload_i(wr_reload_s),
        .wr_cur_i   (wr_cur_s),
        .rd_ctrl_i  (rd_ctrl_s),
        .ctrl_wd_i  (bus_wdata_i[2:0]),
        .reload_wd_i(bus_wdata_i[CNT_W-1:0]),
        .expire_i   (expire_s),
        .en_o       (en_q),
        .tint_o     (tint_q),
        .csrc_o     (csrc_q),
        .flag_o     (flag_q),
        .reload_o   (reload_q),
        .load_o     (load_s),
        .hold_o     (hold_s),
        .step_o     (step_s),
        .irq_o      (irq_o)
    );

    tick_down_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step_s),
        .load_i  (load_s),
        .hold_i  (hold_s),
        .reload_i(reload_q),
        .cur_o   (cur_q),
        .expire_o(expire_s)
    );
endmodule

// File: rtl/tick_timer_chk.sv
// Assertion checker for tick_timer_top, attached by bind below.
// Assumes the internal names en_q, flag_q, reload_q, cur_q and load_s in the top.
module tick_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic              bus_priv_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_rdata_o,
    input logic              bus_err_o,
    input logic              irq_o,
    input logic              en_q,
    input logic              flag_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  cur_q,
    input logic              load_s
);
    logic rd_ok;
    assign rd_ok = bus_sel_i && !bus_wr_i && bus_priv_i;

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_q);

    assert_unpriv_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_priv_i) |-> (bus_err_o && bus_rdata_o == 32'd0));

    assert_unpriv_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_priv_i) |=> $stable(reload_q));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !load_s) |=> $stable(cur_q));

    assert_off_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && bus_addr_i == ADDR_W'(8) && !en_q) |-> bus_rdata_o == 32'd0);

    assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && bus_addr_i == '0) |-> (bus_rdata_o[15:3] == '0 && bus_rdata_o[31:17] == '0));
endmodule

bind tick_timer_top tick_timer_chk #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel_i  (bus_sel_i),
    .bus_wr_i   (bus_wr_i),
    .bus_priv_i (bus_priv_i),
    .bus_addr_i (bus_addr_i),
    .bus_rdata_o(bus_rdata_o),
    .bus_err_o  (bus_err_o),
    .irq_o      (irq_o),
    .en_q       (en_q),
    .flag_q     (flag_q),
    .reload_q   (reload_q),
    .cur_q      (cur_q),
    .load_s     (load_s)
);

// File: tb/tb_tick_timer_top.sv
// Bench for tick_timer_top: behavioural model compared every clock, plus directed checks.
module tb_tick_timer_top;
    localparam int          CNT_W  = 8;
    localparam int          ADDR_W = 5;
    localparam int unsigned MASK   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_tick = 1'b0;
    logic              sel = 1'b0, wr = 1'b0, priv = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              err, irq;

    int    n_tests = 0, n_fail = 0;
    bit    ref_auto = 0;
    int    ph = 0;
    string cur_tag = "R1";

    // model state
    bit          m_en, m_ti, m_cs, m_flag, m_irq;
    int unsigned m_rld, m_cur;

    tick_timer_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CAL_VALUE(32'd10000)) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_priv_i(priv), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_err_o(err), .irq_o(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // reference tick pattern: high one cycle in three when enabled
    always @(posedge clk) begin
        #1;
        if (ref_auto) begin
            ph = (ph + 1) % 3;
            ref_tick = (ph == 0);
        end else begin
            ref_tick = 1'b0;
        end
    end

    // behavioural model, updated on every edge from the driven inputs
    always @(posedge clk) begin
        bit ok, wc, wrl, wcu, rc, ld, hd, st, ex;
        int unsigned nc;
        if (!rst_n) begin
            m_en = 0; m_ti = 0; m_cs = 0; m_flag = 0; m_irq = 0; m_rld = 0; m_cur = 0;
        end else begin
            ok  = sel && priv && (addr[1:0] == 0) && (addr < 16);
            wc  = ok && wr && (addr == 0);
            wrl = ok && wr && (addr == 4);
            wcu = ok && wr && (addr == 8);
            rc  = ok && !wr && (addr == 0);
            ld  = wcu || (wc && wdata[0] && (!m_en || (wdata[2] != m_cs)));
            hd  = wc || wcu;
            st  = m_en && (m_cs || ref_tick) && !hd;
            ex  = st && (m_cur == 1);
            nc  = m_cur;
            if (ld) nc = m_rld;
            else if (st) nc = (m_cur == 0) ? m_rld : m_cur - 1;
            m_irq = ex && m_ti;
            if (wcu) m_flag = 0;
            else if (ex) m_flag = 1;
            else if (rc) m_flag = 0;
            if (wc) begin
                m_en = wdata[0]; m_ti = wdata[1]; m_cs = wdata[2];
            end else if (ex && m_rld == 0) begin
                m_en = 0;
            end
            if (wrl) m_rld = wdata & MASK;
            m_cur = nc;
        end
    end

    function automatic logic [31:0] model_rdata();
        if (!priv || addr[1:0] != 0 || addr >= 16) return 32'd0;
        case (addr[3:2])
            2'd0: return (32'(m_flag) << 16) | (32'(m_cs) << 2) | (32'(m_ti) << 1) | 32'(m_en);
            2'd1: return m_rld;
            2'd2: return m_en ? m_cur : 32'd0;
            default: return 32'd10000;
        endcase
    endfunction

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 irq", {31'd0, irq}, {31'd0, m_irq});
            if (sel) chk("R11 err", {31'd0, err}, {31'd0, !priv});
            if (sel && !wr) chk(cur_tag, rdata, model_rdata());
        end
    end

    task automatic bus(input bit w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input bit p, output logic [31:0] q, output logic e);
        @(posedge clk); #1;
        sel = 1; wr = w; addr = a; wdata = d; priv = p;
        @(negedge clk);
        q = rdata; e = err;
        @(posedge clk); #1;
        sel = 0; wr = 0; priv = 1;
    endtask

    task automatic wrt(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [31:0] q; logic e;
        bus(1, a, d, 1, q, e);
    endtask

    task automatic rdr(input logic [ADDR_W-1:0] a, output logic [31:0] q);
        logic e;
        bus(0, a, 32'd0, 1, q, e);
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] q;
        logic e;
        int pulses;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        cur_tag = "R1";
        rdr(5'h0, q); chk("R1 ctrl", q, 0);
        rdr(5'h4, q); chk("R1 reload", q, 0);
        rdr(5'h8, q); chk("R1 cur", q, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2: only bits [2:0] written
        cur_tag = "R2";
        wrt(5'h0, 32'hFFFF_FFF8);
        rdr(5'h0, q); chk("R2 ctrl", q, 0);

        // R12: reload truncation
        cur_tag = "R12";
        wrt(5'h4, 32'h0000_01FF);
        rdr(5'h4, q); chk("R12 reload", q, 32'hFF);

        // R3: calibration and unmapped offsets
        cur_tag = "R3";
        rdr(5'hC, q);  chk("R3 cal", q, 32'd10000);
        rdr(5'h10, q); chk("R3 high", q, 0);
        rdr(5'h2, q);  chk("R3 misaligned", q, 0);
        wrt(5'h14, 32'd5);
        wrt(5'h6, 32'd5);
        rdr(5'h4, q);  chk("R3 writes ignored", q, 32'hFF);

        // R4: enable loads, reference mode counts only on ticks
        cur_tag = "R4";
        wrt(5'h4, 32'd40);
        wrt(5'h0, 32'h1);
        repeat (5) @(posedge clk);
        rdr(5'h8, q); chk("R4 held without ticks", q, 40);
        ref_auto = 1;
        repeat (30) @(posedge clk);
        rdr(5'h8, q); chk("R4 counted down", {31'd0, q < 40}, 1);
        ref_auto = 0;

        // R5: period reload+1 in core mode with interrupt
        cur_tag = "R5";
        wrt(5'h4, 32'd5);
        wrt(5'h0, 32'h7);
        for (int i = 0; i < 40 && !irq; i++) @(negedge clk);
        pulses = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        chk("R5 pulses in 60 cycles", pulses, 10);

        // R7: control read clears the flag
        cur_tag = "R7";
        wrt(5'h0, 32'h0);
        rdr(5'h0, q); chk("R7 flag seen", q, 32'h0001_0000);
        rdr(5'h0, q); chk("R7 flag cleared", q, 0);

        // R10: clock-source change while enabled reloads
        cur_tag = "R10";
        wrt(5'h4, 32'd3);
        wrt(5'h0, 32'h5);
        repeat (20) @(posedge clk);
        wrt(5'h0, 32'h1);
        rdr(5'h8, q); chk("R10 reloaded", q, 3);

        // R8: current write reloads and clears the flag
        cur_tag = "R8";
        wrt(5'h4, 32'd60);
        wrt(5'h8, 32'hDEAD);
        rdr(5'h0, q); chk("R8 flag cleared", q, 32'h1);
        rdr(5'h8, q); chk("R8 reloaded", q, 60);

        // R9: zero reload stops the timer at expiry
        cur_tag = "R9";
        wrt(5'h4, 32'd4);
        wrt(5'h0, 32'h5);
        wrt(5'h4, 32'd0);
        repeat (10) @(posedge clk);
        rdr(5'h0, q); chk("R9 enable cleared", q, 32'h0001_0004);

        // R6: disabled counter reads 0
        cur_tag = "R6";
        rdr(5'h8, q); chk("R6 disabled reads 0", q, 0);

        // R11: unprivileged accesses
        cur_tag = "R11";
        bus(1, 5'h4, 32'd77, 0, q, e); chk("R11 write err", {31'd0, e}, 1);
        bus(1, 5'h0, 32'h1, 0, q, e);
        bus(0, 5'h0, 32'd0, 0, q, e);
        chk("R11 read err", {31'd0, e}, 1);
        chk("R11 read data", q, 0);
        rdr(5'h4, q); chk("R11 reload untouched", q, 0);
        rdr(5'h0, q); chk("R11 ctrl untouched", q, 32'h4);

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule